// File: doc/BRIEF.md
# Halfword Fetch Realigner

This block links a word-wide instruction memory port to the decoder of a small core that runs a mix of 16-bit and 32-bit instructions. The program counter may point at any halfword, but memory returns only naturally aligned 32-bit words. The block issues word-aligned reads and picks the halfword that the program counter names. It hands the decoder one instruction at a time in normal bit order, with a flag that marks a compressed instruction and the address of the instruction that follows.

A 32-bit instruction that begins in the upper half of a word is split over two memory words. The block keeps the upper half of the first word, reads the following word, and joins the two halves so that the held half sits in the low bits. There is no prefetch queue. Every instruction starts with a fresh read of its own word, even when that word was just read, and any fetched half that is not needed is discarded. A jump input loads a new program counter at any time and abandons the fetch in progress.

Top module: `halfword_fetch_aligner`

## Requirements
- R1: A synchronous reset clears the instruction-valid output, sets the program counter to the parameter RESET_VEC and holds the controller idle; in the first cycle after reset memReq is low, and the first request then goes to the word that holds RESET_VEC.
- R2: A memory request address is always the program counter with bits [1:0] cleared, or that word address plus 4 for the second half of a split instruction. memReq and memAddr stay unchanged until memAck is seen, unless a jump occurs.
- R3: When the program counter has bit 1 clear and the addressed halfword has bits [1:0] equal to 2'b11, instWord is the whole fetched word and instCompressed is 0.
- R4: A halfword whose bits [1:0] are not 2'b11 is compressed: instCompressed is 1 and instWord holds that halfword in bits [15:0] and zero in bits [31:16], whichever half of the word it came from.
- R5: When bit 1 of the program counter is set and the upper halfword is not compressed, a second request goes to the next word, and instWord is {second word [15:0], first word [31:16]}.
- R6: instPc is the address of the presented instruction and instNextPc is instPc + 2 for a compressed instruction and instPc + 4 otherwise; after instAck the next fetch starts at instNextPc.
- R7: instValid, once high, stays high with instWord, instCompressed, instPc and instNextPc unchanged until instAck is seen, unless a jump occurs.
- R8: jumpValid has priority over everything else: the program counter takes jumpPc with bit 0 cleared, any fetch or presented instruction is dropped (a memAck in the same cycle is ignored), and the next cycle requests the word that holds the target.
- R9: At most one memory request is open at a time; memReq and instValid are never high together, so each instruction is read anew from memory after the previous one is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| jumpValid | input | 1 | Load a new program counter this cycle |
| jumpPc | input | ADDR_W | Jump target; bit 0 is ignored |
| memReq | output | 1 | Memory read request, held until acknowledged |
| memAddr | output | ADDR_W | Word-aligned read address |
| memAck | input | 1 | Read data valid this cycle |
| memData | input | 32 | Read data word |
| instValid | output | 1 | Instruction presented to the decoder |
| instAck | input | 1 | Decoder accepts the presented instruction |
| instWord | output | 32 | Instruction in normal bit order |
| instCompressed | output | 1 | Presented instruction is 16 bits wide |
| instPc | output | ADDR_W | Address of the presented instruction |
| instNextPc | output | ADDR_W | Address of the following instruction |

## Verification
The embedded properties assume that memAck is given only while memReq is high and that instAck is given only while instValid is high. They also assume that memData is a word read from memAddr in the acknowledge cycle. The bench drives its memory and decoder models from the sampled request and valid outputs, so it acknowledges only what is pending. It returns the word at the sampled address and places junk on memData in every other cycle. Jumps land at random cycles, including cycles that carry a memory acknowledge, and jump targets may have bit 0 set.

// File: rtl/realign_pkg.sv
package realign_pkg;
  localparam int ILEN = 32;
  localparam int HALF = ILEN / 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH_FIRST,
    ST_FETCH_SECOND,
    ST_VALID
  } fetchState_t;

  typedef struct packed {
    logic takeJump;     // load jump target, drop everything
    logic latchFirst;   // first word arrived
    logic latchSecond;  // second word of a split instruction arrived
    logic advance;      // decoder took the instruction
    logic secondWord;   // address the following word
  } dpStrobe_t;

  function automatic logic isCompressed(input logic [HALF-1:0] half);
    return half[1:0] != 2'b11;
  endfunction
endpackage

// File: rtl/realign_ctrl.sv
module realign_ctrl
  import realign_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      jumpValid,
  input  logic      memAck,
  input  logic      instAck,
  input  logic      pcUpper,
  input  logic      firstCompressed,
  output logic      memReq,
  output logic      instValid,
  output dpStrobe_t strobe
);
  fetchState_t stateQ, stateD;
  logic        needSecond;

  assign needSecond = pcUpper && !firstCompressed;
  assign memReq     = (stateQ == ST_FETCH_FIRST) || (stateQ == ST_FETCH_SECOND);
  assign instValid  = (stateQ == ST_VALID);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    strobe.secondWord = (stateQ == ST_FETCH_SECOND);
    if (jumpValid) begin
      strobe.takeJump = 1'b1;
      stateD          = ST_FETCH_FIRST;
    end else begin
      unique case (stateQ)
        ST_IDLE: stateD = ST_FETCH_FIRST;
        ST_FETCH_FIRST: if (memAck) begin
          strobe.latchFirst = 1'b1;
          stateD = needSecond ? ST_FETCH_SECOND : ST_VALID;
        end
        ST_FETCH_SECOND: if (memAck) begin
          strobe.latchSecond = 1'b1;
          stateD = ST_VALID;
        end
        ST_VALID: if (instAck) begin
          strobe.advance = 1'b1;
          stateD = ST_FETCH_FIRST;
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  // R2
  req_held_chk: assert property (@(posedge clk) disable iff (rst)
    memReq && !memAck && !jumpValid |=> memReq);
  // R7
  valid_held_chk: assert property (@(posedge clk) disable iff (rst)
    instValid && !instAck && !jumpValid |=> instValid);
  // R8
  jump_refetch_chk: assert property (@(posedge clk) disable iff (rst)
    jumpValid |=> memReq && !instValid);
  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(memReq && instValid));
endmodule

// File: rtl/realign_dp.sv
module realign_dp
  import realign_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] jumpPc,
  input  logic [ILEN-1:0]   memData,
  output logic              pcUpper,
  output logic              firstCompressed,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ILEN-1:0]   instWord,
  output logic              instCompressed,
  output logic [ADDR_W-1:0] instPc,
  output logic [ADDR_W-1:0] instNextPc
);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] HALF_MASK = ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] pcQ;
  logic [HALF-1:0]   heldQ;
  logic [ILEN-1:0]   wordQ;
  logic              compQ;
  logic [HALF-1:0]   pickedHalf;

  assign pcUpper         = pcQ[1];
  assign pickedHalf      = pcUpper ? memData[ILEN-1:HALF] : memData[HALF-1:0];
  assign firstCompressed = isCompressed(pickedHalf);
  assign memAddr         = (pcQ & WORD_MASK) + (strobe.secondWord ? WORD_STEP : '0);
  assign instWord        = wordQ;
  assign instCompressed  = compQ;
  assign instPc          = pcQ;
  assign instNextPc      = pcQ + (compQ ? HALF_STEP : WORD_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ   <= RESET_VEC & HALF_MASK;
      heldQ <= '0;
      wordQ <= '0;
      compQ <= 1'b0;
    end else if (strobe.takeJump) begin
      pcQ <= jumpPc & HALF_MASK;
    end else if (strobe.latchFirst) begin
      if (firstCompressed) begin
        wordQ <= {{HALF{1'b0}}, pickedHalf};
        compQ <= 1'b1;
      end else if (!pcUpper) begin
        wordQ <= memData;
        compQ <= 1'b0;
      end else begin
        heldQ <= pickedHalf;
        compQ <= 1'b0;
      end
    end else if (strobe.latchSecond) begin
      wordQ <= {memData[HALF-1:0], heldQ};
    end else if (strobe.advance) begin
      pcQ <= instNextPc;
    end
  end

  // R4
  comp_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.advance && compQ |-> wordQ[ILEN-1:HALF] == '0);
  // R6
  pc_halfword_chk: assert property (@(posedge clk) disable iff (rst)
    pcQ[0] == 1'b0);
endmodule

// File: rtl/halfword_fetch_aligner.sv
module halfword_fetch_aligner
  import realign_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = ADDR_W'(32'h0000_0100)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              jumpValid,
  input  logic [ADDR_W-1:0] jumpPc,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [31:0]       memData,
  output logic              instValid,
  input  logic              instAck,
  output logic [31:0]       instWord,
  output logic              instCompressed,
  output logic [ADDR_W-1:0] instPc,
  output logic [ADDR_W-1:0] instNextPc
);
  dpStrobe_t strobe;
  logic      pcUpper;
  logic      firstCompressed;

  realign_ctrl u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .jumpValid       (jumpValid),
    .memAck          (memAck),
    .instAck         (instAck),
    .pcUpper         (pcUpper),
    .firstCompressed (firstCompressed),
    .memReq          (memReq),
    .instValid       (instValid),
    .strobe          (strobe)
  );

  realign_dp #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_dp (
    .clk             (clk),
    .rst             (rst),
    .strobe          (strobe),
    .jumpPc          (jumpPc),
    .memData         (memData),
    .pcUpper         (pcUpper),
    .firstCompressed (firstCompressed),
    .memAddr         (memAddr),
    .instWord        (instWord),
    .instCompressed  (instCompressed),
    .instPc          (instPc),
    .instNextPc      (instNextPc)
  );

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    memReq && !memAck && !jumpValid |=> $stable(memAddr));
  // R2
  addr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    memReq |-> memAddr[1:0] == 2'b00);
  // R7
  word_stable_chk: assert property (@(posedge clk) disable iff (rst)
    instValid && !instAck && !jumpValid |=> $stable(instWord) && $stable(instPc));
  // R4
  comp_flag_chk: assert property (@(posedge clk) disable iff (rst)
    instValid |-> instCompressed == (instWord[1:0] != 2'b11));
  // R8
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    jumpValid |=> memAddr == ($past(jumpPc) & ~ADDR_W'(3)));
endmodule

// File: tb/tb_halfword_fetch_aligner.sv
module tb_halfword_fetch_aligner;
  localparam int          AW = 32;
  localparam logic [31:0] RV = 32'h0000_0100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          jumpValid = 1'b0;
  logic [AW-1:0] jumpPc = '0;
  logic          memReq;
  logic [AW-1:0] memAddr;
  logic          memAck = 1'b0;
  logic [31:0]   memData = '0;
  logic          instValid;
  logic          instAck = 1'b0;
  logic [31:0]   instWord;
  logic          instCompressed;
  logic [AW-1:0] instPc;
  logic [AW-1:0] instNextPc;

  always #2 clk = ~clk;

  halfword_fetch_aligner #(.ADDR_W(AW), .RESET_VEC(RV)) dut (
    .clk(clk), .rst(rst), .jumpValid(jumpValid), .jumpPc(jumpPc),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .instValid(instValid), .instAck(instAck), .instWord(instWord),
    .instCompressed(instCompressed), .instPc(instPc), .instNextPc(instNextPc)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // program memory contents, addressed by halfword
  function automatic logic [15:0] halfAt(input logic [31:0] a);
    logic [31:0] v;
    logic [1:0]  lo;
    v  = (a >> 1) * 32'h9E37_79B1;
    v  = v ^ (v >> 13);
    lo = v[4] ? ((v[1:0] == 2'b11) ? 2'b10 : v[1:0]) : 2'b11;
    return {v[15:2], lo};
  endfunction

  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [31:0] w;
    w = a & ~32'h3;
    return {halfAt(w + 2), halfAt(w)};
  endfunction

  function automatic bit halfIsComp(input logic [15:0] h);
    return h[1:0] != 2'b11;
  endfunction

  logic [31:0] mPc;
  bit          mSecond, mValid, jumpedLast, firstReq;
  logic [31:0] lastJump;
  int          retired = 0, straddles = 0, drops = 0, sinceRetire = 0;
  bit          hung = 0;

  initial begin
    logic [15:0] h0;
    logic [31:0] expWord;
    bit          expComp;
    mPc = RV; mSecond = 0; mValid = 0; jumpedLast = 0; firstReq = 1; lastJump = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: idle cycle right after reset
    check(memReq == 1'b0, "R1 memReq idle", 32'(memReq), 32'h0);
    check(instValid == 1'b0, "R1 instValid idle", 32'(instValid), 32'h0);

    for (int cyc = 0; cyc < 8000 && !hung; cyc++) begin
      @(negedge clk);
      // ---- compare outputs with the model
      check(memReq == !mValid, "R9 memReq", 32'(memReq), 32'(!mValid));
      check(instValid == mValid, "R7 instValid", 32'(instValid), 32'(mValid));
      if (firstReq) begin
        check(memAddr == RV, "R1 first request", memAddr, RV);
        firstReq = 0;
      end
      if (jumpedLast)
        check(memAddr == (lastJump & ~32'h3), "R8 target word", memAddr, lastJump & ~32'h3);
      if (memReq)
        check(memAddr == ((mPc & ~32'h3) + (mSecond ? 32'd4 : 32'd0)), "R2 address",
              memAddr, (mPc & ~32'h3) + (mSecond ? 32'd4 : 32'd0));
      if (instValid) begin
        h0 = halfAt(mPc);
        expComp = halfIsComp(h0);
        expWord = expComp ? {16'h0, h0} : {halfAt(mPc + 2), h0};
        if (expComp)      check(instWord == expWord, "R4 compressed word", instWord, expWord);
        else if (!mPc[1]) check(instWord == expWord, "R3 aligned word", instWord, expWord);
        else              check(instWord == expWord, "R5 joined word", instWord, expWord);
        check(instCompressed == expComp, "R4 flag", 32'(instCompressed), 32'(expComp));
        check(instPc == mPc, "R6 instPc", instPc, mPc);
        check(instNextPc == mPc + (expComp ? 32'd2 : 32'd4), "R6 instNextPc",
              instNextPc, mPc + (expComp ? 32'd2 : 32'd4));
      end
      // ---- drive stimulus for the coming edge
      jumpValid = ($urandom % 37) == 0;
      jumpPc    = 32'h200 + ($urandom % 256);
      memAck    = memReq && (($urandom % 3) != 0);
      memData   = memAck ? memWord(memAddr) : 32'hDEAD_BEEF ^ $urandom;
      instAck   = instValid && (($urandom % 2) == 0);
      // ---- advance the model as the edge will
      if (jumpValid) begin
        if (memAck) drops++;
        mPc = jumpPc & ~32'h1; mSecond = 0; mValid = 0;
        jumpedLast = 1; lastJump = jumpPc;
      end else begin
        jumpedLast = 0;
        if (memAck) begin
          if (!mSecond && mPc[1] && !halfIsComp(halfAt(mPc))) begin
            mSecond = 1;
            straddles++;
          end else begin
            mSecond = 0; mValid = 1;
          end
        end else if (instAck) begin
          mPc = mPc + (halfIsComp(halfAt(mPc)) ? 32'd2 : 32'd4);
          mValid = 0; retired++; sinceRetire = 0;
        end
      end
      sinceRetire++;
      if (sinceRetire > 300) hung = 1;
    end
    jumpValid = 0; memAck = 0; instAck = 0;
    check(!hung, "R6 watchdog progress", 32'(sinceRetire), 32'd300);
    check(retired > 500, "R6 instructions retired", 32'(retired), 32'd500);
    check(straddles > 0, "R5 split fetches seen", 32'(straddles), 32'd1);
    check(drops > 0, "R8 acks dropped on jump", 32'(drops), 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule